// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Engine

This block sends and receives asynchronous serial characters over a pair of single-wire lines. Each character has a low start bit, eight data bits sent least significant bit first, an optional extra bit, and one or two high stop bits. The line is high while idle. Four format inputs set the frame. They enable parity, choose even or odd parity, choose one or two stop bits, and select a multiprocessor format. In the multiprocessor format the extra bit carries a caller-supplied flag instead of parity.

Bit timing comes from an external `tick` strobe, 16 ticks to a bit. The transmit side takes a byte over a valid/ready handshake. The receive side finds a falling edge and confirms the start bit at its centre. It samples every later bit at the centre of that bit. It then presents the byte with parity, framing and overrun flags. These stay held until the consumer pulses `rx_ack`.

The format inputs are captured when each character begins. Changing them in the middle of a character has no effect until the next one.

Top module: `async_frame_engine`

## Requirements
- R1: After reset `txd` is 1 and `tx_ready` is 1. The transmitter accepts a byte in the cycle `tx_valid` and `tx_ready` are both 1, and `tx_ready` then stays 0 until the frame ends. The frame is a 0 start bit, then the data with bit 0 first, then the optional extra bit, then the stop bits at 1. Each bit lasts exactly 16 ticks.
- R2: With `cfg_par_en`=1 and `cfg_mp_fmt`=0, an extra parity bit follows the data. With `cfg_par_odd`=0 it makes the count of ones over data and parity even; with `cfg_par_odd`=1 it makes that count odd. With `cfg_par_en`=0, no parity bit is sent and `cfg_par_odd` has no effect.
- R3: `cfg_two_stop`=0 appends one stop bit and `cfg_two_stop`=1 appends two, both at 1.
- R4: With `cfg_mp_fmt`=1 the extra bit is sent as `tx_mpb`, whatever `cfg_par_en` and `cfg_par_odd` are. The received extra bit appears on `rx_mpb`. `rx_mpb` is 0 for characters received with `cfg_mp_fmt`=0.
- R5: A received character raises `rx_valid` with the byte on `rx_data`. All receive outputs hold until `rx_ack` is 1 for a cycle, which clears `rx_valid`.
- R6: A low pulse on `rxd` that has ended by the start-bit centre (8 ticks after the falling edge) produces no character.
- R7: `rx_perr` is 1 when parity is enabled and the combined count of ones over data and parity bit does not match the selected sense. It is 0 whenever `cfg_par_en`=0 or `cfg_mp_fmt`=1.
- R8: Only the first stop bit is checked on receive: `rx_ferr` is 1 when it is 0. A 0 in the position of a second stop bit begins the next character, whatever `cfg_two_stop` is.
- R9: If a character completes while `rx_valid` is 1 and `rx_ack` is 0, `rx_ovr` becomes 1 and `rx_data` keeps the older byte. `rx_ack` clears `rx_ovr` together with `rx_valid`.
- R10: The format inputs are captured at the start of each character, on both sides. Changing them during the character does not alter that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling strobe, 16 per bit |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 selects two transmitted stop bits |
| cfg_mp_fmt | input | 1 | Multiprocessor format select |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | DATA_W | Transmit byte |
| tx_mpb | input | 1 | Extra bit sent in multiprocessor format |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_ack | input | 1 | Consumer takes the held byte |
| rx_valid | output | 1 | A received byte is held |
| rx_data | output | DATA_W | Received byte |
| rx_mpb | output | 1 | Received multiprocessor bit |
| rx_perr | output | 1 | Parity error for held byte |
| rx_ferr | output | 1 | Framing error for held byte |
| rx_ovr | output | 1 | A later character was lost |

## Verification
On transmit, `txd` falls in the cycle after the handshake edge, and each later bit starts on the clock edge that consumes the 16th tick of the bit before it. The bench therefore counts ticks from the handshake and reads `txd` at a falling clock edge after the 8th tick of each bit. It reads `tx_ready` after the 16th tick of the last bit.

On receive, the result lands one clock after the tick at the centre of the first stop bit. The bench reads the receive outputs only after that stop bit has been fully driven, and it checks the clear one clock after `rx_ack`. Inputs and `tick` change on falling edges, so the design sees stable values.

// File: rtl/afe_pkg.sv
package afe_pkg;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
    logic mp_fmt;
  } afe_txfmt_t;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic mp_fmt;
  } afe_rxfmt_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_FRAME = 2'd2
  } afe_rx_st_e;

endpackage

// File: rtl/afe_tx.sv
module afe_tx
  import afe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  afe_txfmt_t        fmt,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mpb,
  output logic              in_ready,
  output logic              line
);

  localparam int CW = $clog2(OSR);
  localparam int SW = DATA_W + 3;
  localparam int BW = $clog2(DATA_W + 4);
  localparam logic [CW-1:0] TLAST = CW'(OSR - 1);

  logic          busy_q, busy_d;
  logic          line_q, line_d;
  logic [SW-1:0] sh_q, sh_d;
  logic [BW-1:0] left_q, left_d;
  logic [CW-1:0] tc_q, tc_d;
  logic          has_x, xbit, accept;

  // next-state
  always_comb begin
    has_x = fmt.mp_fmt | fmt.par_en;
    if (fmt.mp_fmt)      xbit = in_mpb;
    else if (fmt.par_en) xbit = (^in_data) ^ fmt.par_odd;
    else                 xbit = 1'b1;
    accept = in_valid & ~busy_q;

    busy_d = busy_q;
    line_d = line_q;
    sh_d   = sh_q;
    left_d = left_q;
    tc_d   = tc_q;

    if (accept) begin
      busy_d = 1'b1;
      line_d = 1'b0;
      sh_d   = {2'b11, xbit, in_data};
      left_d = BW'(DATA_W + 1) + BW'(has_x) + BW'(fmt.two_stop);
      tc_d   = '0;
    end else if (busy_q && tick) begin
      if (tc_q == TLAST) begin
        tc_d = '0;
        if (left_q == '0) begin
          busy_d = 1'b0;
          line_d = 1'b1;
        end else begin
          line_d = sh_q[0];
          sh_d   = {1'b1, sh_q[SW-1:1]};
          left_d = left_q - 1'b1;
        end
      end else begin
        tc_d = tc_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      line_q <= 1'b1;
      sh_q   <= '1;
      left_q <= '0;
      tc_q   <= '0;
    end else begin
      busy_q <= busy_d;
      line_q <= line_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      tc_q   <= tc_d;
    end
  end

  assign in_ready = ~busy_q;
  assign line     = line_q;

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> line) else $error("idle line low"); // R1
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!line && !in_ready)) else $error("no start bit"); // R1
  AST_TX_TICK_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(line)) else $error("line moved without tick"); // R1

endmodule

// File: rtl/afe_rx.sv
module afe_rx
  import afe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              mp_fmt,
  input  logic              line,
  input  logic              ack,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              mpb,
  output logic              perr,
  output logic              ferr,
  output logic              ovr
);

  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] TLAST = CW'(OSR - 1);
  localparam logic [CW-1:0] THALF = CW'(OSR / 2 - 1);

  logic              s1_q, s2_q, pv_q;
  afe_rx_st_e        st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              xb_q, xb_d;
  afe_rxfmt_t        lf_q, lf_d;
  logic              val_q, val_d, ovr_q, ovr_d, mpb_q, mpb_d;
  logic              perr_q, perr_d, ferr_q, ferr_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              done, fall, has_x, busy_hold;

  // line synchronizer and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      pv_q <= 1'b1;
    end else begin
      s1_q <= line;
      s2_q <= s1_q;
      pv_q <= s2_q;
    end
  end

  // frame sequencer next-state
  always_comb begin
    fall  = pv_q & ~s2_q;
    has_x = lf_q.par_en | lf_q.mp_fmt;
    done  = 1'b0;
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    xb_d  = xb_q;
    lf_d  = lf_q;
    case (st_q)
      RX_IDLE: begin
        if (fall) begin
          st_d  = RX_START;
          cnt_d = '0;
          lf_d  = '{par_en: par_en, par_odd: par_odd, mp_fmt: mp_fmt};
        end
      end
      RX_START: begin
        if (tick) begin
          if (cnt_q == THALF) begin
            cnt_d = '0;
            idx_d = '0;
            st_d  = s2_q ? RX_IDLE : RX_FRAME;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_FRAME: begin
        if (tick) begin
          if (cnt_q == TLAST) begin
            cnt_d = '0;
            idx_d = idx_q + 1'b1;
            if (idx_q < IW'(DATA_W)) begin
              sh_d = {s2_q, sh_q[DATA_W-1:1]};
            end else if (idx_q == IW'(DATA_W) && has_x) begin
              xb_d = s2_q;
            end else begin
              done = 1'b1;
              st_d = RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  // result hold next-state
  always_comb begin
    busy_hold = val_q & ~ack;
    val_d  = val_q;
    ovr_d  = ovr_q;
    dat_d  = dat_q;
    mpb_d  = mpb_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    if (done) begin
      if (busy_hold) begin
        ovr_d = 1'b1;
      end else begin
        val_d  = 1'b1;
        ovr_d  = 1'b0;
        dat_d  = sh_q;
        mpb_d  = lf_q.mp_fmt & xb_q;
        perr_d = lf_q.par_en & ~lf_q.mp_fmt & (((^sh_q) ^ xb_q) != lf_q.par_odd);
        ferr_d = ~s2_q;
      end
    end else if (ack) begin
      val_d = 1'b0;
      ovr_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      xb_q   <= 1'b0;
      lf_q   <= '0;
      val_q  <= 1'b0;
      ovr_q  <= 1'b0;
      dat_q  <= '0;
      mpb_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      xb_q   <= xb_d;
      lf_q   <= lf_d;
      val_q  <= val_d;
      ovr_q  <= ovr_d;
      dat_q  <= dat_d;
      mpb_q  <= mpb_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
    end
  end

  assign valid = val_q;
  assign data  = dat_q;
  assign mpb   = mpb_q;
  assign perr  = perr_q;
  assign ferr  = ferr_q;
  assign ovr   = ovr_q;

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ack) |=> $stable(data)) else $error("held byte replaced"); // R9
  AST_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> valid) else $error("overrun without byte"); // R9
  AST_NO_PERR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (!lf_q.par_en || lf_q.mp_fmt) && !(valid && !ack)) |=> !perr)
    else $error("parity error while unchecked"); // R7
  AST_MPB_ONLY_MP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !lf_q.mp_fmt && !(valid && !ack)) |=> !mpb)
    else $error("mp bit outside mp format"); // R4

endmodule

// File: rtl/async_frame_engine.sv
module async_frame_engine
  import afe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_mp_fmt,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_mpb,
  output logic              tx_ready,
  output logic              txd,
  input  logic              rxd,
  input  logic              rx_ack,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_ovr
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  afe_txfmt_t tx_fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign tx_fmt = '{par_en: cfg_par_en, par_odd: cfg_par_odd,
                    two_stop: cfg_two_stop, mp_fmt: cfg_mp_fmt};

  afe_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick),
    .fmt      (tx_fmt),
    .in_valid (tx_valid),
    .in_data  (tx_data),
    .in_mpb   (tx_mpb),
    .in_ready (tx_ready),
    .line     (txd)
  );

  afe_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .par_en  (cfg_par_en),
    .par_odd (cfg_par_odd),
    .mp_fmt  (cfg_mp_fmt),
    .line    (rxd),
    .ack     (rx_ack),
    .valid   (rx_valid),
    .data    (rx_data),
    .mpb     (rx_mpb),
    .perr    (rx_perr),
    .ferr    (rx_ferr),
    .ovr     (rx_ovr)
  );

endmodule

// File: tb/async_frame_engine_bench.sv
module async_frame_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  int         div_cnt = 0;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0, cfg_mp_fmt = 1'b0;
  logic       tx_valid = 1'b0, tx_mpb = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, txd;
  logic       rxd = 1'b1, rx_ack = 1'b0;
  logic       rx_valid, rx_mpb, rx_perr, rx_ferr, rx_ovr;
  logic [7:0] rx_data;
  int         n_cmp = 0, n_bad = 0;
  int unsigned seed_val;

  async_frame_engine u_async_frame_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_mp_fmt(cfg_mp_fmt),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_mpb(tx_mpb),
    .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_ack(rx_ack), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_mpb(rx_mpb), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (div_cnt == TDIV - 1) begin div_cnt <= 0; tick <= 1'b1; end
    else begin div_cnt <= div_cnt + 1; tick <= 1'b0; end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_tick;
    do @(posedge clk); while (tick !== 1'b1);
  endtask

  function automatic logic [11:0] tx_bits(input logic [7:0] d, input logic mpb,
                                          input logic pe, input logic odd, input logic mp);
    logic [11:0] b;
    b = '1;
    b[0] = 1'b0;
    b[8:1] = d;
    if (mp)      b[9] = mpb;
    else if (pe) b[9] = (^d) ^ odd;
    return b;
  endfunction

  function automatic int tx_len(input logic pe, input logic two, input logic mp);
    return 10 + ((pe | mp) ? 1 : 0) + (two ? 1 : 0);
  endfunction

  task automatic tx_frame(input logic [7:0] d, input logic mpb, input logic flip, input string req);
    logic [11:0] e;
    int n;
    logic [3:0] saved;
    e = tx_bits(d, mpb, cfg_par_en, cfg_par_odd, cfg_mp_fmt);
    n = tx_len(cfg_par_en, cfg_two_stop, cfg_mp_fmt);
    saved = {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt};
    @(negedge clk);
    tx_data = d; tx_mpb = mpb; tx_valid = 1'b1;
    while (tx_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(req, "tx_ready while busy", 32'(tx_ready), 32'd0);
    if (flip) {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = ~saved;
    for (int j = 0; j < n; j++) begin
      repeat (8) wait_tick;
      @(negedge clk);
      chk(req, $sformatf("txd bit %0d of %02h", j, d), 32'(txd), 32'(e[j]));
      repeat (8) wait_tick;
    end
    @(negedge clk);
    chk(req, "tx_ready after frame", 32'(tx_ready), 32'd1);
    chk(req, "txd idle", 32'(txd), 32'd1);
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = saved;
  endtask

  task automatic rx_bit(input logic b, input int ticks);
    @(negedge clk);
    rxd = b;
    repeat (ticks) wait_tick;
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic has_x, input logic xb,
                          input logic stop1, input logic flip);
    logic [3:0] saved;
    saved = {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt};
    rx_bit(1'b0, 16);
    if (flip) {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = ~saved;
    for (int i = 0; i < 8; i++) rx_bit(d[i], 16);
    if (has_x) rx_bit(xb, 16);
    rx_bit(stop1, 16);
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = saved;
  endtask

  task automatic do_ack(input string req);
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
    chk(req, "rx_valid after ack", 32'(rx_valid), 32'd0);
    chk(req, "rx_ovr after ack", 32'(rx_ovr), 32'd0);
  endtask

  task automatic rx_expect(input logic [7:0] d, input logic mpb, input logic perr,
                           input logic ferr, input string req);
    int k;
    k = 0;
    while (rx_valid !== 1'b1 && k < 3000) begin @(negedge clk); k++; end
    chk(req, "rx_valid", 32'(rx_valid), 32'd1);
    chk(req, "rx_data", 32'(rx_data), 32'(d));
    chk(req, "rx_mpb", 32'(rx_mpb), 32'(mpb));
    chk(req, "rx_perr", 32'(rx_perr), 32'(perr));
    chk(req, "rx_ferr", 32'(rx_ferr), 32'(ferr));
    chk(req, "rx_ovr", 32'(rx_ovr), 32'd0);
    do_ack(req);
  endtask

  function automatic logic exp_perr(input logic [7:0] d, input logic xb);
    return cfg_par_en & ~cfg_mp_fmt & (((^d) ^ xb) != cfg_par_odd);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic xb, st;
    seed_val = $urandom(32'h5eed1234);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1", "reset txd", 32'(txd), 32'd1);
    chk("R1", "reset tx_ready", 32'(tx_ready), 32'd1);
    chk("R5", "reset rx_valid", 32'(rx_valid), 32'd0);
    chk("R9", "reset rx_ovr", 32'(rx_ovr), 32'd0);

    // directed transmit cases
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b0000;
    tx_frame(8'h5A, 1'b0, 1'b0, "R1");
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b1010;
    tx_frame(8'h00, 1'b0, 1'b0, "R2_even_R3_two");
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b1100;
    tx_frame(8'hFF, 1'b0, 1'b0, "R2_odd");
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b0100;
    tx_frame(8'h81, 1'b0, 1'b0, "R2_off_R3_one");
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b1101;
    tx_frame(8'h3C, 1'b1, 1'b0, "R4_mp1");
    tx_frame(8'h3D, 1'b0, 1'b0, "R4_mp0");
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b1000;
    tx_frame(8'hC3, 1'b0, 1'b1, "R10_tx");

    // random transmit
    for (int i = 0; i < 14; i++) begin
      {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'($urandom);
      tx_frame(8'($urandom), 1'($urandom), 1'b0, "R1_R2_R3_R4_rand");
    end

    // directed receive cases
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b0000;
    rx_frame(8'hA5, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (30) @(negedge clk);
    chk("R5", "rx_valid held", 32'(rx_valid), 32'd1);
    rx_expect(8'hA5, 1'b0, 1'b0, 1'b0, "R5");

    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b1000;
    rx_frame(8'hA5, 1'b1, 1'b0, 1'b1, 1'b0);
    rx_expect(8'hA5, 1'b0, 1'b0, 1'b0, "R7_even_ok");
    rx_frame(8'hA5, 1'b1, 1'b1, 1'b1, 1'b0);
    rx_expect(8'hA5, 1'b0, 1'b1, 1'b0, "R7_even_bad");
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b1100;
    rx_frame(8'h07, 1'b1, 1'b1, 1'b1, 1'b0);
    rx_expect(8'h07, 1'b0, 1'b1, 1'b0, "R7_odd_bad");
    rx_frame(8'h07, 1'b1, 1'b0, 1'b1, 1'b0);
    rx_expect(8'h07, 1'b0, 1'b0, 1'b0, "R7_odd_ok");

    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b1001;
    rx_frame(8'h01, 1'b1, 1'b0, 1'b1, 1'b0);
    rx_expect(8'h01, 1'b0, 1'b0, 1'b0, "R4_R7_mp0");
    rx_frame(8'h01, 1'b1, 1'b1, 1'b1, 1'b0);
    rx_expect(8'h01, 1'b1, 1'b0, 1'b0, "R4_mp1");

    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b0000;
    rx_frame(8'h6E, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_bit(1'b1, 16);
    rx_expect(8'h6E, 1'b0, 1'b0, 1'b1, "R8_ferr");

    // second stop position low starts the next character
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b0010;
    fork
      begin
        rx_frame(8'h12, 1'b0, 1'b0, 1'b1, 1'b0);
        rx_frame(8'h34, 1'b0, 1'b0, 1'b1, 1'b0);
        rx_bit(1'b1, 16);
      end
      begin
        rx_expect(8'h12, 1'b0, 1'b0, 1'b0, "R8_first");
        rx_expect(8'h34, 1'b0, 1'b0, 1'b0, "R8_second_start");
      end
    join

    // overrun
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b0000;
    rx_frame(8'hAA, 1'b0, 1'b0, 1'b1, 1'b0);
    rx_frame(8'h55, 1'b0, 1'b0, 1'b1, 1'b0);
    rx_bit(1'b1, 4);
    chk("R9", "rx_valid on overrun", 32'(rx_valid), 32'd1);
    chk("R9", "rx_ovr", 32'(rx_ovr), 32'd1);
    chk("R9", "older byte kept", 32'(rx_data), 32'hAA);
    do_ack("R9");

    // short glitch
    rx_bit(1'b0, 3);
    rx_bit(1'b1, 40);
    chk("R6", "no character from glitch", 32'(rx_valid), 32'd0);

    // format change mid-character
    {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'b1000;
    rx_frame(8'h0F, 1'b1, 1'b0, 1'b1, 1'b1);
    rx_expect(8'h0F, 1'b0, 1'b0, 1'b0, "R10_rx");

    // random receive
    for (int i = 0; i < 14; i++) begin
      {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_mp_fmt} = 4'($urandom);
      d = 8'($urandom);
      xb = 1'($urandom);
      st = ($urandom % 4) != 0;
      rx_frame(d, cfg_par_en | cfg_mp_fmt, xb, st, 1'b0);
      if (!st) rx_bit(1'b1, 16);
      rx_expect(d, cfg_mp_fmt & xb, exp_perr(d, xb), ~st, "R5_R7_R8_rand");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule